// File: doc/BRIEF.md
# Processor Core Power-Up Sequencer

This block brings one processor core out of its unpowered state for the first time. A single start pulse launches a fixed hardware sequence. The sequence drives two control words toward the core's power switches and isolation logic: a per-core power control word and a power-gate control word. Clamps, head switches and resets are released in a strict order, with timed settling gaps between the stages that need them.

Every settling gap is timed by one shared down-counter. The length of a gap is `WAIT_US * CYC_PER_US` clock cycles, so the integrator sets `CYC_PER_US` to match the clock frequency. When the final powered-up bit is set, the block emits a one-cycle done pulse. It then returns to idle and holds both words. A further start pulse given in idle runs the sequence again from its first step.

Top module: `core_pwrup_seq`

## Requirements
- R1: Reset (active-low `rst_ni`) clears both control words to zero, holds `done_o` low and returns the sequencer to idle, including when reset arrives in the middle of a sequence.
- R2: A start pulse sampled in idle sets the power control word to 0x33 on that clock edge. This value has bit 0 (clamp), bit 1 (memory clamp), bit 4 (core reset) and bit 5 (power-on reset) set and every other bit clear.
- R3: On the next edge the gate word becomes 0x1000_0001: enable at bit 0 and a head-switch count of 16 in bits 31:24. The power control word then stays unchanged for W = WAIT_US*CYC_PER_US cycles.
- R4: The step that follows that gap clears only bit 1 (memory clamp). On the edge after it, bit 3 (memory head switch) is set, and another gap of W cycles follows.
- R5: After the second gap, bit 0 (clamp) is cleared, and a third gap of W cycles follows.
- R6: After the third gap, bit 4 and bit 5 are cleared together on one edge.
- R7: One edge later, bit 7 (powered up) is set. `done_o` is high for exactly that cycle. Both words are then held unchanged while idle.
- R8: Within a sequence, each step changes only the bits it names and keeps every other control bit at its previous value.
- R9: A start pulse that arrives while a sequence is running has no effect on either word or on the timing.
- R10: The gap length follows the parameters, down to the smallest legal gap of 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; acted on only in idle |
| core_ctl_o | output | CTL_W | Per-core power control word |
| gate_ctl_o | output | GATE_W | Power-gate control word |
| done_o | output | 1 | One-cycle pulse when the powered-up bit is set |

## Verification
The bench builds two instances that share one start and one reset. The first uses CYC_PER_US = 5 and WAIT_US = 2, which gives 10-cycle gaps. The second uses CYC_PER_US = 1, which gives the minimum gap of 2 cycles, where the timer is loaded with zero. Because both instances are compared cycle by cycle against a timeline derived from W, a gap that is off by one cycle shows up at once. The same holds for a bit change that is moved into a different step. A start pulse injected in mid-run falls at different points of the two sequences, and a second run confirms that the gate word is left unchanged when it is rewritten.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GATE,
      ST_MEMCLR,
      ST_MEMHS,
      ST_CLAMPOFF,
      ST_RSTOFF,
      ST_PWRD,
      ST_WAIT
   } seq_state_e;

   typedef enum logic [2:0] {
      STEP_NONE,
      STEP_ENTRY,
      STEP_GATE,
      STEP_MEMCLR,
      STEP_MEMHS,
      STEP_CLAMPOFF,
      STEP_RSTOFF,
      STEP_PWRD
   } seq_step_e;

   // bit positions decoded by the core power logic
   localparam int BIT_CLAMP   = 0;
   localparam int BIT_MCLAMP  = 1;
   localparam int BIT_MHS     = 3;
   localparam int BIT_CRST    = 4;
   localparam int BIT_PORST   = 5;
   localparam int BIT_PWRD    = 7;

   localparam int GATE_EN_BIT  = 0;
   localparam int GATE_CNT_LSB = 24;
   localparam int GATE_CNT_W   = 8;

endpackage

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
   import pwrup_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      start_i,
   input  logic      expired_i,
   output seq_step_e step_o,
   output logic      load_o
);

   seq_state_e state_q, state_d;
   seq_state_e ret_q, ret_d;

   always_comb begin
      state_d = state_q;
      ret_d   = ret_q;
      step_o  = STEP_NONE;
      load_o  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               step_o  = STEP_ENTRY;
               state_d = ST_GATE;
            end
         end
         ST_GATE: begin
            step_o  = STEP_GATE;
            load_o  = 1'b1;
            ret_d   = ST_MEMCLR;
            state_d = ST_WAIT;
         end
         ST_MEMCLR: begin
            step_o  = STEP_MEMCLR;
            state_d = ST_MEMHS;
         end
         ST_MEMHS: begin
            step_o  = STEP_MEMHS;
            load_o  = 1'b1;
            ret_d   = ST_CLAMPOFF;
            state_d = ST_WAIT;
         end
         ST_CLAMPOFF: begin
            step_o  = STEP_CLAMPOFF;
            load_o  = 1'b1;
            ret_d   = ST_RSTOFF;
            state_d = ST_WAIT;
         end
         ST_RSTOFF: begin
            step_o  = STEP_RSTOFF;
            state_d = ST_PWRD;
         end
         ST_PWRD: begin
            step_o  = STEP_PWRD;
            state_d = ST_IDLE;
         end
         ST_WAIT: begin
            if (expired_i) state_d = ret_q;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         ret_q   <= ST_IDLE;
      end else begin
         state_q <= state_d;
         ret_q   <= ret_d;
      end
   end

endmodule

// File: rtl/pwrup_words.sv
module pwrup_words
   import pwrup_pkg::*;
#(
   parameter int CTL_W    = 32,
   parameter int GATE_W   = 32,
   parameter int HS_COUNT = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  seq_step_e         step_i,
   output logic [CTL_W-1:0]  ctl_o,
   output logic [GATE_W-1:0] gate_o,
   output logic              done_o
);

   logic [CTL_W-1:0]  set_m, clr_m;
   logic [GATE_W-1:0] gate_val;

   always_comb begin
      set_m = '0;
      clr_m = '0;
      unique case (step_i)
         STEP_ENTRY: begin
            clr_m             = '1;
            set_m[BIT_CLAMP]  = 1'b1;
            set_m[BIT_MCLAMP] = 1'b1;
            set_m[BIT_CRST]   = 1'b1;
            set_m[BIT_PORST]  = 1'b1;
         end
         STEP_MEMCLR:   clr_m[BIT_MCLAMP] = 1'b1;
         STEP_MEMHS:    set_m[BIT_MHS]    = 1'b1;
         STEP_CLAMPOFF: clr_m[BIT_CLAMP]  = 1'b1;
         STEP_RSTOFF: begin
            clr_m[BIT_CRST]  = 1'b1;
            clr_m[BIT_PORST] = 1'b1;
         end
         STEP_PWRD:     set_m[BIT_PWRD]   = 1'b1;
         default: ;
      endcase
   end

   // one flop per control bit: set wins over clear, otherwise hold
   for (genvar b = 0; b < CTL_W; b++) begin : g_ctl_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)       ctl_o[b] <= 1'b0;
         else if (set_m[b]) ctl_o[b] <= 1'b1;
         else if (clr_m[b]) ctl_o[b] <= 1'b0;
      end
   end

   always_comb begin
      gate_val = '0;
      gate_val[GATE_EN_BIT] = 1'b1;
      gate_val[GATE_CNT_LSB +: GATE_CNT_W] = GATE_CNT_W'(HS_COUNT);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gate_o <= '0;
         done_o <= 1'b0;
      end else begin
         if (step_i == STEP_GATE) gate_o <= gate_val;
         done_o <= (step_i == STEP_PWRD);
      end
   end

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
   import pwrup_pkg::*;
#(
   parameter int CYC_PER_US = 50,
   parameter int WAIT_US    = 2,
   parameter int HS_COUNT   = 16,
   parameter int CTL_W      = 32,
   parameter int GATE_W     = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   output logic [CTL_W-1:0]  core_ctl_o,
   output logic [GATE_W-1:0] gate_ctl_o,
   output logic              done_o
);

   localparam int WAIT_CYC = WAIT_US * CYC_PER_US;
   localparam int CNT_W    = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;
   // the wait state plus the step that closes it account for two cycles
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC - 2);

   if (WAIT_CYC < 2) begin : g_bad_wait
      $error("core_pwrup_seq: WAIT_US*CYC_PER_US must be at least 2");
   end
   if (CTL_W < BIT_PWRD + 1) begin : g_bad_ctl
      $error("core_pwrup_seq: CTL_W too narrow for the powered-up bit");
   end
   if (GATE_W < GATE_CNT_LSB + GATE_CNT_W) begin : g_bad_gate
      $error("core_pwrup_seq: GATE_W too narrow for the count field");
   end
   if (HS_COUNT >= (1 << GATE_CNT_W) || HS_COUNT < 0) begin : g_bad_cnt
      $error("core_pwrup_seq: HS_COUNT does not fit its field");
   end

   seq_step_e step;
   logic      load, expired;

   pwrup_fsm u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .expired_i (expired),
      .step_o    (step),
      .load_o    (load)
   );

   pwrup_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .load_val_i (LOAD_VAL),
      .expired_o  (expired)
   );

   pwrup_words #(
      .CTL_W    (CTL_W),
      .GATE_W   (GATE_W),
      .HS_COUNT (HS_COUNT)
   ) u_words (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (step),
      .ctl_o  (core_ctl_o),
      .gate_o (gate_ctl_o),
      .done_o (done_o)
   );

endmodule

// File: rtl/pwrup_checker.sv
module pwrup_checker
   import pwrup_pkg::*;
#(
   parameter int CTL_W  = 32,
   parameter int GATE_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [CTL_W-1:0]  core_ctl_o,
   input logic [GATE_W-1:0] gate_ctl_o,
   input logic              done_o
);

   AST_MEMHS_AFTER_UNCLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(core_ctl_o[BIT_MHS]) |-> (!core_ctl_o[BIT_MCLAMP] && !$past(core_ctl_o[BIT_MCLAMP]))); // R4
   AST_CLAMP_AFTER_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(core_ctl_o[BIT_CLAMP]) |-> core_ctl_o[BIT_MHS]); // R5
   AST_RESETS_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_ctl_o[BIT_CRST] == core_ctl_o[BIT_PORST]); // R6
   AST_DONE_ON_PWRD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> $rose(core_ctl_o[BIT_PWRD])); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R7
   AST_STEP_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(core_ctl_o) != '0 && !$past(core_ctl_o[BIT_PWRD]))
         |-> ($countones(core_ctl_o ^ $past(core_ctl_o)) <= 2)); // R8
   AST_GATE_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_ctl_o != $past(gate_ctl_o)) |-> ($past(gate_ctl_o) == '0)); // R3

endmodule

bind core_pwrup_seq pwrup_checker #(.CTL_W(CTL_W), .GATE_W(GATE_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .core_ctl_o (core_ctl_o),
   .gate_ctl_o (gate_ctl_o),
   .done_o     (done_o)
);

// File: tb/core_pwrup_seq_tb_top.sv
module core_pwrup_seq_tb_top;

   localparam int WUS  = 2;
   localparam int CPUA = 5;
   localparam int CPUB = 1;
   localparam int WA   = WUS * CPUA;
   localparam int WB   = WUS * CPUB;
   localparam logic [31:0] GATE_ON = 32'h1000_0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [31:0] ctl_a, gate_a, ctl_b, gate_b;
   logic done_a, done_b;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   core_pwrup_seq #(.CYC_PER_US(CPUA), .WAIT_US(WUS)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .core_ctl_o(ctl_a), .gate_ctl_o(gate_a), .done_o(done_a));

   core_pwrup_seq #(.CYC_PER_US(CPUB), .WAIT_US(WUS)) dut_min_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .core_ctl_o(ctl_b), .gate_ctl_o(gate_b), .done_o(done_b));

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_ctl(input int k, input int w);
      if (k <= w)              return 32'h33;
      else if (k == w + 1)     return 32'h31;
      else if (k <= 2*w + 1)   return 32'h39;
      else if (k <= 3*w + 1)   return 32'h38;
      else if (k == 3*w + 2)   return 32'h08;
      else                     return 32'h88;
   endfunction

   function automatic string tag_of(input int k, input int w);
      if (k == 0)            return "R2";
      else if (k <= w)       return "R3";
      else if (k <= 2*w + 1) return "R4";
      else if (k <= 3*w + 1) return "R5";
      else if (k == 3*w + 2) return "R6";
      else                   return "R7";
   endfunction

   task automatic cmp_one(input string name, input int k, input int w, input bit gate_pre,
                          input string extra, input logic [31:0] ctl, input logic [31:0] prev,
                          input logic [31:0] gate, input logic done);
      string tg;
      logic [31:0] eg;
      tg = {tag_of(k, w), extra};
      eg = (k >= 1 || gate_pre) ? GATE_ON : 32'h0;
      chk(ctl == exp_ctl(k, w), tg, {name, " ctl"}, ctl, exp_ctl(k, w));
      chk(gate == eg, tg, {name, " gate"}, gate, eg);
      chk(done == (k == 3*w + 3), tg, {name, " done"}, 32'(done), 32'(k == 3*w + 3));
      if (k > 0 && k <= 3*w + 3)
         chk($countones(ctl ^ prev) <= 2, {"R8", extra}, {name, " bits changed"},
             32'($countones(ctl ^ prev)), 32'd2);
   endtask

   // start in idle, then compare both instances every cycle; optionally
   // inject a start pulse mid-run at cycle ign_k (R9)
   task automatic run_seq(input int ign_k, input bit gate_pre);
      logic [31:0] pa, pb;
      string ex;
      ex = (ign_k >= 0) ? " R9" : "";
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      pa = ctl_a;
      pb = ctl_b;
      for (int k = 0; k <= 3*WA + 6; k++) begin
         if (k > 0) @(negedge clk);
         cmp_one("A", k, WA, gate_pre, ex, ctl_a, pa, gate_a, done_a);
         cmp_one("B", k, WB, gate_pre, {ex, " R10"}, ctl_b, pb, gate_b, done_b);
         pa = ctl_a;
         pb = ctl_b;
         start = (k == ign_k);
      end
      start = 1'b0;
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      chk(ctl_a == 0 && gate_a == 0 && done_a == 0, "R1", "A in reset", ctl_a | gate_a, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(ctl_a == 0 && gate_a == 0 && done_a == 0, "R1", "A idle after reset", ctl_a | gate_a, 0);
      chk(ctl_b == 0 && gate_b == 0 && done_b == 0, "R1", "B idle after reset", ctl_b | gate_b, 0);
   endtask

   task automatic t_reset_mid;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (4) @(negedge clk);
      chk(ctl_a == 32'h33, "R1", "A mid-run before reset", ctl_a, 32'h33);
      rst_n = 1'b0;
      @(negedge clk);
      chk(ctl_a == 0 && gate_a == 0, "R1", "A cleared by reset", ctl_a | gate_a, 0);
      chk(ctl_b == 0 && gate_b == 0, "R1", "B cleared by reset", ctl_b | gate_b, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset_state();
      run_seq(-1, 1'b0);
      repeat (5) @(negedge clk);
      chk(ctl_a == 32'h88 && gate_a == GATE_ON, "R7", "A holds in idle", ctl_a, 32'h88);
      run_seq(5, 1'b1);
      t_reset_mid();
      run_seq(-1, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule